// File: doc/BRIEF.md
# Four-Lane Interleave and Shuffle Unit

This block rearranges 32-bit lanes between two 128-bit source vectors. Each vector holds four lanes, and lane 0 sits in bits [31:0]. A 3-bit operation code picks one of five permutes:

- an interleave of the lower 32-bit lanes;
- an interleave of the upper 32-bit lanes;
- a pairing of the lower 64-bit halves;
- a pairing of the upper 64-bit halves;
- a shuffle in which an 8-bit immediate chooses, for each result lane, a source lane.

Lane contents are opaque bit patterns. No arithmetic is done on them.

A request is accepted on a valid/ready handshake. Its result is registered and presented one cycle later. The output register stalls while the consumer holds ready low. With the two interleave widths alone, four row vectors of a 4x4 matrix become its four column vectors in eight operations.

Top module: `lane_perm_unit`

## Requirements
- R1: Opcode 0 (low 32-bit interleave) gives result lanes 3..0 = {b1, a1, b0, a0}.
- R2: Opcode 1 (high 32-bit interleave) gives result lanes 3..0 = {b3, a3, b2, a2}.
- R3: Opcode 2 (low 64-bit pairing) gives bits [63:0] = a[63:0] and bits [127:64] = b[63:0].
- R4: Opcode 3 (high 64-bit pairing) gives bits [63:0] = a[127:64] and bits [127:64] = b[127:64].
- R5: Opcode 4 (shuffle): result lane k takes the source lane numbered by imm[2k+1:2k]. Lanes 0 and 1 take it from a, and lanes 2 and 3 take it from b. An immediate of 0x00, 0x55, 0xAA or 0xFF broadcasts lane 0, 1, 2 or 3.
- R6: Opcodes 5, 6 and 7 return a unchanged with out_err = 1. Opcodes 0 to 4 return out_err = 0.
- R7: While rst_n is low, out_valid is 0 and in_ready is 1.
- R8: While out_valid = 1 and out_ready = 0, in_ready is 0, and out_data, out_err and out_valid hold their values.
- R9: A request accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid = 1 after that edge. With no new acceptance and out_ready = 1, out_valid falls at the next edge.
- R10: When a held result is drained in the same cycle that a new request is accepted, out_valid stays 1 and out_data takes the new result.
- R11: Opcode 0 and opcode 1 applied to row pairs (r0,r1) and (r2,r3), then opcode 2 and opcode 3 applied to those intermediates, yield the four columns of the 4x4 matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op | input | 3 | Permute selector |
| imm | input | 8 | Shuffle lane selectors, two bits per result lane |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Registered result vector |
| out_err | output | 1 | Registered flag for an undefined opcode |

## Verification
Two things can fall in the same cycle: a held result is drained, and a fresh request is loaded. The bench first parks a result under a stalled consumer, with a different request already waiting. It then raises out_ready. At the next edge out_valid must stay high and out_data must change straight to the waiting request's result. The bench also confirms that no stale value is exposed and no result is lost.

// File: rtl/lane_perm_pkg.sv
package lane_perm_pkg;

  typedef enum logic [2:0] {
    OP_ILV_LO32 = 3'd0,
    OP_ILV_HI32 = 3'd1,
    OP_ILV_LO64 = 3'd2,
    OP_ILV_HI64 = 3'd3,
    OP_SHUFFLE  = 3'd4
  } perm_op_e;

  localparam int unsigned OP_LAST_DEFINED = 4;

  function automatic logic op_defined(input logic [2:0] code);
    return code <= 3'(OP_LAST_DEFINED);
  endfunction

endpackage

// File: rtl/perm_interleave.sv
// Pairs element i of a with element i of b. "lo" draws from the lower half
// of each source and "hi" from the upper half; a elements go to even slots.
module perm_interleave #(
  parameter int ELEM_W = 32,
  parameter int N_ELEM = 4
) (
  input  logic [ELEM_W*N_ELEM-1:0] a,
  input  logic [ELEM_W*N_ELEM-1:0] b,
  output logic [ELEM_W*N_ELEM-1:0] lo,
  output logic [ELEM_W*N_ELEM-1:0] hi
);
  localparam int HALF = N_ELEM / 2;

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign lo[(2*i)*ELEM_W   +: ELEM_W] = a[i*ELEM_W +: ELEM_W];
    assign lo[(2*i+1)*ELEM_W +: ELEM_W] = b[i*ELEM_W +: ELEM_W];
    assign hi[(2*i)*ELEM_W   +: ELEM_W] = a[(HALF+i)*ELEM_W +: ELEM_W];
    assign hi[(2*i+1)*ELEM_W +: ELEM_W] = b[(HALF+i)*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/perm_shuffle.sv
// Result lane k picks source lane imm[k]; lower half of result from a,
// upper half from b.
module perm_shuffle #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0]       a,
  input  logic [VEC_W-1:0]       b,
  input  logic [SEL_W*LANES-1:0] imm,
  output logic [VEC_W-1:0]       y
);
  function automatic logic [LANE_W-1:0] pick_lane(input logic [VEC_W-1:0] v,
                                                  input logic [SEL_W-1:0] idx);
    return v[idx*LANE_W +: LANE_W];
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = imm[k*SEL_W +: SEL_W];
    if (k < LANES/2) begin : g_from_a
      assign y[k*LANE_W +: LANE_W] = pick_lane(a, sel);
    end else begin : g_from_b
      assign y[k*LANE_W +: LANE_W] = pick_lane(b, sel);
    end
  end
endmodule

// File: rtl/perm_out_stage.sv
// One-entry registered output with valid/ready flow control.
module perm_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         out_ready,
  input  logic [W-1:0] d_data,
  input  logic         d_err,
  output logic         out_valid,
  output logic [W-1:0] q_data,
  output logic         q_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_data    <= '0;
      q_err     <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      q_data    <= d_data;
      q_err     <= d_err;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lane_perm_unit.sv
module lane_perm_unit #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int SEL_W = $clog2(LANES),
  localparam int IMM_W = SEL_W * LANES,
  localparam int VEC_W = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       op,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_err
);
  import lane_perm_pkg::*;

  logic [VEC_W-1:0] lo32, hi32, lo64, hi64, shuf;
  logic [VEC_W-1:0] next_data;
  logic             next_err;
  logic             accept;

  perm_interleave #(.ELEM_W(LANE_W), .N_ELEM(LANES)) u_ilv32 (
    .a(src_a), .b(src_b), .lo(lo32), .hi(hi32)
  );

  perm_interleave #(.ELEM_W(2*LANE_W), .N_ELEM(LANES/2)) u_ilv64 (
    .a(src_a), .b(src_b), .lo(lo64), .hi(hi64)
  );

  perm_shuffle #(.LANE_W(LANE_W), .LANES(LANES)) u_shuf (
    .a(src_a), .b(src_b), .imm(imm), .y(shuf)
  );

  always_comb begin
    next_err = !op_defined(op);
    case (perm_op_e'(op))
      OP_ILV_LO32: next_data = lo32;
      OP_ILV_HI32: next_data = hi32;
      OP_ILV_LO64: next_data = lo64;
      OP_ILV_HI64: next_data = hi64;
      OP_SHUFFLE:  next_data = shuf;
      default:     next_data = src_a;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  perm_out_stage #(.W(VEC_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .take(accept), .out_ready(out_ready),
    .d_data(next_data), .d_err(next_err),
    .out_valid(out_valid), .q_data(out_data), .q_err(out_err)
  );
endmodule

// File: rtl/lane_perm_unit_chk.sv
module lane_perm_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             accept,
  input logic [2:0]       op,
  input logic [VEC_W-1:0] src_a,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data,
  input logic             out_err
);
  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid) |=> out_valid);

  assert_bad_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op > 3'd4) |=> (out_err && out_data == $past(src_a)));

  assert_good_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op <= 3'd4) |=> !out_err);
endmodule

bind lane_perm_unit lane_perm_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .accept(accept), .op(op), .src_a(src_a), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
);

// File: tb/lane_perm_unit_tb.sv
`timescale 1ns/1ps
module lane_perm_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   op = '0;
  logic [7:0]   imm = '0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_err;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lane_perm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .imm(imm), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_err(out_err)
  );

  localparam logic [31:0] A0 = 32'hA0A0A0A0, A1 = 32'hA1A1A1A1,
                          A2 = 32'hA2A2A2A2, A3 = 32'hA3A3A3A3;
  localparam logic [31:0] B0 = 32'hB0B0B0B0, B1 = 32'hB1B1B1B1,
                          B2 = 32'hB2B2B2B2, B3 = 32'hB3B3B3B3;
  localparam logic [127:0] VA = {A3, A2, A1, A0};
  localparam logic [127:0] VB = {B3, B2, B1, B0};

  localparam int NV = 11;
  localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4,
                                       3'd4, 3'd4, 3'd4, 3'd5, 3'd7};
  localparam logic [7:0] T_IMM [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF,
                                        8'h1B, 8'hE4, 8'h55, 8'h00, 8'hFF};
  localparam logic [127:0] T_EXP [NV] = '{
    {B1, A1, B0, A0},   // R1
    {B3, A3, B2, A2},   // R2
    {B1, B0, A1, A0},   // R3
    {B3, B2, A3, A2},   // R4
    {B0, B0, A0, A0},   // R5 broadcast lane 0
    {B3, B3, A3, A3},   // R5 broadcast lane 3
    {B0, B1, A2, A3},   // R5 reversed order
    {B3, B2, A1, A0},   // R5 identity order
    {B1, B1, A1, A1},   // R5 broadcast lane 1
    VA,                 // R6 undefined opcode
    VA                  // R6 undefined opcode
  };
  localparam logic T_ERR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                  1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam string T_REQ [NV] = '{"R1", "R2", "R3", "R4", "R5", "R5",
                                   "R5", "R5", "R5", "R6", "R6"};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, accept at the next rising edge, sample after it.
  task automatic issue(input logic [2:0] o, input logic [7:0] i,
                       input logic [127:0] a, input logic [127:0] b,
                       output logic [127:0] res, output logic err);
    @(negedge clk);
    op = o; imm = i; src_a = a; src_b = b; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", {127'd0, out_valid}, 128'd1);
    res = out_data;
    err = out_err;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] r;
    logic         e;
    logic [127:0] held;

    // R7: reset state
    repeat (2) @(negedge clk);
    chk("R7", {127'd0, out_valid}, 128'd0);
    chk("R7", {127'd0, in_ready}, 128'd1);
    rst_n = 1'b1;

    // Vector table: R1..R6
    for (int n = 0; n < NV; n++) begin
      issue(T_OP[n], T_IMM[n], VA, VB, r, e);
      chk(T_REQ[n], r, T_EXP[n]);
      chk(T_REQ[n], {127'd0, e}, {127'd0, T_ERR[n]});
    end

    // R9: result drains one edge later when nothing new arrives
    @(negedge clk);
    chk("R9", {127'd0, out_valid}, 128'd0);

    // R11: transpose of random matrices
    for (int m = 0; m < 3; m++) begin
      logic [31:0]  el [4][4];
      logic [127:0] row [4];
      logic [127:0] t [4];
      logic [127:0] col [4];
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) el[i][j] = $urandom;
      for (int i = 0; i < 4; i++) row[i] = {el[i][3], el[i][2], el[i][1], el[i][0]};
      issue(3'd0, 8'h00, row[0], row[1], t[0], e);
      issue(3'd0, 8'h00, row[2], row[3], t[1], e);
      issue(3'd1, 8'h00, row[0], row[1], t[2], e);
      issue(3'd1, 8'h00, row[2], row[3], t[3], e);
      issue(3'd2, 8'h00, t[0], t[1], col[0], e);
      issue(3'd3, 8'h00, t[0], t[1], col[1], e);
      issue(3'd2, 8'h00, t[2], t[3], col[2], e);
      issue(3'd3, 8'h00, t[2], t[3], col[3], e);
      for (int j = 0; j < 4; j++)
        chk("R11", col[j], {el[3][j], el[2][j], el[1][j], el[0][j]});
    end

    // R8 / R10: stall, then drain and load in the same cycle
    @(negedge clk);
    out_ready = 1'b0;
    op = 3'd1; imm = 8'h00; src_a = VA; src_b = VB; in_valid = 1'b1;
    @(negedge clk);
    held = out_data;
    chk("R8", held, {B3, A3, B2, A2});
    op = 3'd5; src_a = VB; src_b = VA;     // different request waiting
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R8", {126'd0, out_valid, in_ready}, {126'd0, 1'b1, 1'b0});
      chk("R8", out_data, held);
      chk("R8", {127'd0, out_err}, 128'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", {127'd0, out_valid}, 128'd1);
    chk("R10", out_data, VB);
    chk("R10", {127'd0, out_err}, 128'd1);
    @(negedge clk);
    chk("R9", {127'd0, out_valid}, 128'd0);

    // R7: reset in the middle of a held result
    out_ready = 1'b0;
    issue(3'd0, 8'h00, VA, VB, r, e);
    out_ready = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R7", {126'd0, out_valid, in_ready}, {126'd0, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule